// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit timer channel. A counting-clock enable (`tick_en`) sets the pace, and a `gate` input either pauses counting or restarts it, depending on the mode. The block drives one waveform output. A register interface outside the block supplies a count value, a three-bit mode and a load strobe. The channel returns the live count and the output level so they can be read back.

Six waveforms are available: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square wave, and two single-tick strobes (one started by a load, one started by the gate). A loaded value of zero stands for a terminal count of 65536. Internally the channel keeps the elapsed-tick count since the last load or trigger. Both the waveform and the readback value are decoded from that count.

Top module: `pic_channel`

## Requirements
- R1: A loaded value of 0 acts as a terminal count of 65536. In mode 0 the output stays low for 65535 ticks and goes high at tick 65536.
- R2: Mode 0 (load_mode 3'd0). After a load the output is low. It goes high when the elapsed ticks reach the count and then stays high until the next load.
- R3: Mode 1 (3'd1). After a load the output stays high and waits for a rising edge of the gate. After that edge the output is low until the elapsed ticks reach the count, then high.
- R4: Mode 2 (3'd2). The output is high except during the single tick at which the elapsed ticks are a nonzero multiple of the count.
- R5: Mode 3 (3'd3). Within each period of count ticks, the output is high for the first (count+1)/2 ticks and low for the rest.
- R6: Modes 4 (3'd4) and 5 (3'd5). The output idles high and is low for exactly the one tick at which the elapsed ticks equal the count. Mode 5 starts its elapsed count only at a rising edge of the gate.
- R7: In modes 1, 2, 3 and 5, a gate rising edge resets the elapsed ticks to zero. In modes 0 and 4, a low gate pauses counting and a gate edge has no other effect. A load in the same cycle as a gate edge takes priority.
- R8: The readback value is the loaded value minus the elapsed ticks, modulo 65536, in modes 0, 1, 4 and 5. In mode 2 it is count minus (elapsed mod count). In mode 3 it is count minus (2 x elapsed mod count). Both are taken modulo 65536.
- R9: After reset the channel is in mode 3 with a count of 65536. The output is high, the readback is 0, and the gate history is low.
- R10: load_mode values 3'd6 and 3'd7 behave exactly like modes 2 and 3.
- R11: Elapsed ticks advance only in cycles with tick_en high. A load sets the elapsed count to zero in its own cycle, even if tick_en is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting-clock enable, one tick per high cycle |
| gate | input | 1 | Gate level, sampled every clock |
| load_stb | input | 1 | Load strobe for count and mode |
| load_val | input | 16 | Count value (0 means 65536) |
| load_mode | input | 3 | Operating mode |
| cnt_out | output | 16 | Readback count |
| wave_out | output | 1 | Output waveform |

## Verification
On every cycle, the assertions check the properties that span one or two cycles:
- the zero-means-full conversion;
- a pause while the gate is low in the gated modes;
- that nothing moves without a tick;
- that the mode 0 output stays high once set;
- that the strobe and rate-generator low phases last exactly one tick;
- that the one-shot readback steps down by one per tick.

Only the bench's scenarios can show that the waveform shape over a whole period matches the requirement, including the odd-count square wave, the 65536-tick terminal count and the wait for the first trigger. The same holds for the mode aliases and the readback formulas for modes 2 and 3, which the bench compares against a model built on elapsed ticks.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int CNT_W = 16;
  localparam int PER_W = CNT_W + 1;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pic_mode_e;

  // zero written means the full range
  function automatic logic [PER_W-1:0] f_period(input logic [CNT_W-1:0] v);
    return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
  endfunction

  function automatic pic_mode_e f_norm_mode(input logic [2:0] m);
    case (m)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return pic_mode_e'(m);
    endcase
  endfunction

  function automatic logic f_is_oneshot(input pic_mode_e m);
    return (m == M_TERM) || (m == M_ONESHOT) || (m == M_SWSTROBE) || (m == M_HWSTROBE);
  endfunction

  function automatic logic f_gate_pauses(input pic_mode_e m);
    return (m == M_TERM) || (m == M_SWSTROBE);
  endfunction

  function automatic logic f_waits_trigger(input pic_mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTROBE);
  endfunction

  function automatic logic f_gate_retrig(input pic_mode_e m);
    return !f_gate_pauses(m);
  endfunction

  // length of the high phase of a square-wave period
  function automatic logic [PER_W-1:0] f_half_hi(input logic [PER_W-1:0] p);
    logic [PER_W:0] t;
    t = {1'b0, p} + 1'b1;
    return t[PER_W:1];
  endfunction

  // (2*e) mod p, valid for e < p
  function automatic logic [PER_W-1:0] f_dbl_mod(input logic [PER_W-1:0] e,
                                                 input logic [PER_W-1:0] p);
    logic [PER_W:0] d2;
    d2 = {e, 1'b0};
    if (d2 >= {1'b0, p}) d2 = d2 - {1'b0, p};
    return d2[PER_W-1:0];
  endfunction
endpackage

// File: rtl/pic_gate_edge.sv
module pic_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/pic_count_core.sv
module pic_count_core
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             gate_rise,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       load_mode,
  output pic_mode_e        mode_q,
  output logic [PER_W-1:0] period_q,
  output logic [PER_W-1:0] el_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             moved_q,
  output logic             step,
  output logic             restart
);
  pic_mode_e        new_mode;
  logic [PER_W-1:0] new_period;
  logic [PER_W-1:0] el_inc;

  assign new_mode   = f_norm_mode(load_mode);
  assign new_period = f_period(load_val);
  assign el_inc     = el_q + 1'b1;
  assign step       = tick_en && (!f_gate_pauses(mode_q) || gate);
  assign restart    = gate_rise && f_gate_retrig(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_SQUARE;
      period_q <= {1'b1, {CNT_W{1'b0}}};
      el_q     <= '0;
      cnt_q    <= '0;
      moved_q  <= 1'b0;
    end else if (load_stb) begin
      mode_q   <= new_mode;
      period_q <= new_period;
      cnt_q    <= load_val;
      moved_q  <= 1'b0;
      el_q     <= f_waits_trigger(new_mode) ? new_period + 1'b1 : '0;
    end else if (restart) begin
      el_q     <= '0;
      cnt_q    <= period_q[CNT_W-1:0];
      moved_q  <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
      if (f_is_oneshot(mode_q)) begin
        el_q <= (el_q > period_q) ? el_q : el_inc;
      end else begin
        moved_q <= 1'b1;
        el_q    <= (el_inc == period_q) ? '0 : el_inc;
      end
    end
  end

  a_r1_zero_is_full: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb && (load_val == '0) |=> period_q == {1'b1, {CNT_W{1'b0}}});

  a_r7_gate_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb && f_gate_pauses(mode_q) && !gate |=> $stable(el_q) && $stable(cnt_q));

  a_r11_no_tick_still: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb && !restart && !tick_en |=> $stable(el_q) && $stable(cnt_q));

  a_r8_elapsed_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    el_q <= period_q + 1'b1);
endmodule

// File: rtl/pic_output_decode.sv
module pic_output_decode
  import pic_pkg::*;
(
  input  pic_mode_e        mode_q,
  input  logic [PER_W-1:0] period_q,
  input  logic [PER_W-1:0] el_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             moved_q,
  output logic             wave,
  output logic [CNT_W-1:0] count
);
  logic [PER_W-1:0] rate_left;
  logic [PER_W-1:0] sq_left;

  assign rate_left = period_q - el_q;
  assign sq_left   = period_q - f_dbl_mod(el_q, period_q);

  always_comb begin
    case (mode_q)
      M_TERM, M_ONESHOT:       wave = (el_q >= period_q);
      M_SWSTROBE, M_HWSTROBE:  wave = (el_q != period_q);
      M_RATE:                  wave = !((el_q == '0) && moved_q);
      default:                 wave = (el_q < f_half_hi(period_q));
    endcase
  end

  always_comb begin
    case (mode_q)
      M_RATE:   count = rate_left[CNT_W-1:0];
      M_SQUARE: count = sq_left[CNT_W-1:0];
      default:  count = cnt_q;
    endcase
  end
endmodule

// File: rtl/pic_channel.sv
module pic_channel
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       load_mode,
  output logic [CNT_W-1:0] cnt_out,
  output logic             wave_out
);
  logic             gate_rise;
  pic_mode_e        mode_q;
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] el_q;
  logic [CNT_W-1:0] cnt_q;
  logic             moved_q;
  logic             step;
  logic             restart;

  pic_gate_edge u_edge (
    .clk(clk), .rst_n(rst_n), .gate(gate), .gate_rise(gate_rise)
  );

  pic_count_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .gate_rise(gate_rise), .load_stb(load_stb), .load_val(load_val),
    .load_mode(load_mode), .mode_q(mode_q), .period_q(period_q),
    .el_q(el_q), .cnt_q(cnt_q), .moved_q(moved_q), .step(step),
    .restart(restart)
  );

  pic_output_decode u_dec (
    .mode_q(mode_q), .period_q(period_q), .el_q(el_q), .cnt_q(cnt_q),
    .moved_q(moved_q), .wave(wave_out), .count(cnt_out)
  );

  a_r2_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TERM) && wave_out && !load_stb |=> wave_out);

  a_r6_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTROBE) || (mode_q == M_HWSTROBE)) && !wave_out && step
      && !load_stb && !restart |=> wave_out);

  a_r4_rate_low_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE) && !wave_out && step && !load_stb && !restart
      && (period_q > 1) |=> wave_out);

  a_r8_oneshot_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    f_is_oneshot(mode_q) && step && !load_stb && !restart
      |=> cnt_out == $past(cnt_out) - 1'b1);
endmodule

// File: tb/pic_channel_tb.sv
module pic_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  load_mode = '0;
  logic [15:0] cnt_out;
  logic        wave_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state, kept in elapsed-tick terms
  int m_mode  = 3;
  int m_per   = 65536;
  int m_d     = 0;
  bit m_armed = 1;
  bit m_gprev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_stb(load_stb), .load_val(load_val), .load_mode(load_mode),
    .cnt_out(cnt_out), .wave_out(wave_out)
  );

  function automatic bit exp_wave();
    case (m_mode)
      0:       return m_d >= m_per;
      1:       return m_armed ? (m_d >= m_per) : 1'b1;
      2:       return !((m_d % m_per) == 0 && m_d != 0);
      3:       return (m_d % m_per) < ((m_per + 1) / 2);
      default: return m_armed ? (m_d != m_per) : 1'b1;
    endcase
  endfunction

  function automatic int exp_cnt();
    case (m_mode)
      2:       return (m_per - (m_d % m_per)) & 16'hFFFF;
      3:       return (m_per - ((2 * m_d) % m_per)) & 16'hFFFF;
      default: return (m_per - m_d) & 16'hFFFF;
    endcase
  endfunction

  task automatic check(input string rq);
    n_chk++;
    if (wave_out !== exp_wave()) begin
      n_bad++;
      $display("FAIL %s wave: actual %0b expected %0b (mode %0d count %0d d %0d)",
               rq, wave_out, exp_wave(), m_mode, m_per, m_d);
    end
    n_chk++;
    if (cnt_out !== 16'(exp_cnt())) begin
      n_bad++;
      $display("FAIL %s count: actual %0d expected %0d (mode %0d count %0d d %0d)",
               rq, cnt_out, exp_cnt(), m_mode, m_per, m_d);
    end
  endtask

  // one clock with the given inputs, then update the model and compare
  task automatic cyc(input bit ld, input int v, input int md, input bit te,
                     input bit g, input string rq);
    bit rise;
    load_stb  = ld;
    load_val  = 16'(v);
    load_mode = 3'(md);
    tick_en   = te;
    gate      = g;
    @(posedge clk);
    rise = g && !m_gprev;
    if (ld) begin
      m_mode  = (md >= 6) ? md - 4 : md;
      m_per   = (v == 0) ? 65536 : v;
      m_d     = 0;
      m_armed = !(m_mode == 1 || m_mode == 5);
    end else if (rise && !(m_mode == 0 || m_mode == 4)) begin
      m_d     = 0;
      m_armed = 1;
    end else if (te && (!(m_mode == 0 || m_mode == 4) || g)) begin
      m_d++;
    end
    m_gprev = g;
    @(negedge clk);
    load_stb = 1'b0;
    check(rq);
  endtask

  task automatic run(input int n, input bit te, input bit g, input string rq);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, te, g, rq);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R9");
    run(4, 1, 0, "R9");
  endtask

  task automatic t_term();
    cyc(1, 5, 0, 1, 1, "R2");
    run(9, 1, 1, "R2/R8");
  endtask

  task automatic t_zero();
    cyc(1, 0, 0, 1, 1, "R1");
    run(65537, 1, 1, "R1");
  endtask

  task automatic t_oneshot();
    cyc(1, 4, 1, 1, 0, "R3");
    run(3, 1, 0, "R3");
    run(3, 1, 1, "R3");
    run(1, 1, 0, "R7");
    run(7, 1, 1, "R3/R7");
  endtask

  task automatic t_rate();
    cyc(1, 4, 2, 1, 0, "R4");
    run(10, 1, 0, "R4/R8");
    run(6, 1, 1, "R7");
  endtask

  task automatic t_square();
    cyc(1, 5, 3, 1, 0, "R5");
    run(12, 1, 0, "R5/R8");
    cyc(1, 6, 3, 1, 0, "R5");
    run(10, 1, 0, "R5/R8");
  endtask

  task automatic t_strobe();
    cyc(1, 3, 4, 1, 1, "R6");
    run(2, 1, 1, "R6");
    run(3, 1, 0, "R7");
    run(4, 1, 1, "R6");
    cyc(1, 2, 5, 1, 0, "R6");
    run(3, 1, 0, "R6");
    run(5, 1, 1, "R6/R7");
  endtask

  task automatic t_alias();
    cyc(1, 3, 6, 1, 0, "R10");
    run(8, 1, 0, "R10");
    cyc(1, 5, 7, 1, 0, "R10");
    run(8, 1, 0, "R10");
  endtask

  task automatic t_tick();
    cyc(1, 6, 0, 1, 1, "R11");
    run(3, 0, 1, "R11");
    run(2, 1, 1, "R11");
    run(2, 0, 1, "R11");
    cyc(1, 6, 0, 1, 1, "R11");
    run(7, 1, 1, "R11");
  endtask

  initial begin
    t_reset();
    t_term();
    t_oneshot();
    t_rate();
    t_square();
    t_strobe();
    t_alias();
    t_tick();
    t_zero();
    done = 1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule